// File: doc/BRIEF.md
# Low-Frequency Oscillator Start-up and Lock Controller

This block sits beside a low-frequency oscillator and decides when the oscillator runs. The oscillator runs when software forces it on, or when a requester in the chip asks for it and on-demand service has not been turned off. Each time the oscillator is switched on, the block counts oscillator cycles, which arrive as single-cycle `osc_tick` strobes in the system clock domain. When the programmed start-up wait has passed, it reports the oscillator ready.

Four event flags are kept:
- the rise of ready;
- the rise of an external clock-present input;
- the fall of that input;
- an oscillator failure, recorded only when failure detection is switched on.

Each flag is masked and the results are ORed into one registered interrupt line. Software reaches the block through a small 32-bit register bus with a one-cycle read latency. A 16-bit key register protects the control, setup and trim registers against stray writes. The amplitude, mode, gain and capacitance-trim fields are stored and read back but drive nothing here.

Top module: `osc_startup_ctrl`

Register map (byte offsets): 0x00 control, 0x04 setup, 0x08 trim, 0x0C status, 0x10 flags, 0x14 flag mask, 0x18 trim busy, 0x1C key (write-only, reads 0).

## Requirements
- R1: One cycle after the control bits are seen, `osc_en` is 1 when force-enable (control bit 0) is 1, or when `demand_req` is 1 and no-demand (control bit 1) is 0. It is 0 otherwise. With no-demand 1 and force-enable 0 the oscillator is forced off.
- R2: Setup bits 10:8 select the start-up wait in oscillator ticks: codes 0..7 give 2, 256, 1024, 2048, 4096, 8192, 16384 and 32768. `osc_rdy` rises at the clock edge that samples the last tick of that wait, counted from the first tick after `osc_en` rose.
- R3: When the enable is lost, `osc_rdy` falls on the same edge as `osc_en`. The next enable restarts the count from zero.
- R4: The status register (0x0C) reads ready in bit 0, enabled in bit 16 and locked in bit 31. All other bits read 0.
- R5: A write of 6688 (0x1A20) to bits 15:0 of the key register unlocks. A write of any other key value locks. While locked, writes to control, setup and trim are ignored. Reset leaves the block unlocked.
- R6: Writes to setup take effect only while the oscillator is forced off. At other times they are ignored.
- R7: An accepted trim write sets trim-busy (bit 0 of 0x18). The next `osc_tick` clears it. Trim writes made while it is set are ignored.
- R8: Flag bit 0 sets on a rise of `osc_rdy`. Bit 1 sets on a rise of `clk_present` and bit 2 on a fall, each seen after a two-stage synchronizer.
- R9: Flag bit 3 sets while `osc_fail` is 1 only if failure-detect (control bit 4) is 1.
- R10: Writing 1 to a flag bit at 0x10 clears it. Writing 0 leaves it unchanged. A new event in the same cycle wins over the clear.
- R11: `irq` is 1 one cycle after any flag bit is set together with its mask bit at 0x14 (same bit positions), and 0 one cycle after none is.
- R12: All registers reset to 0. Control keeps only bits 0, 1, 4, 5. Setup keeps bits 0, 1, 5:4 and 10:8. Trim keeps bits 6:0 and 9:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe; data appears the next cycle |
| bus_rdata | output | 32 | Registered read data |
| osc_tick | input | 1 | One-cycle strobe per oscillator cycle |
| demand_req | input | 1 | On-demand request for the oscillator |
| clk_present | input | 1 | Asynchronous clock-present indication |
| osc_fail | input | 1 | Oscillator failure indication |
| osc_en | output | 1 | Oscillator enable |
| osc_rdy | output | 1 | Oscillator ready |
| irq | output | 1 | Masked interrupt request |

## Verification
The start-up counter is run with wait code 1 (256 ticks) and with code 0 (2 ticks). In each run, ready is sampled one tick before the wait ends and again at the tick that ends it, so an off-by-one in the wait or a wrong table entry shows up. A disable and re-enable between the two runs, with a check after the first tick of the new count, tells a restarted count from a continued one. Writes are tried in pairs: once while they should land and once while they should be dropped (locked, not forced off, trim busy). This tells the lock, the forced-off gate and the busy gate apart. The flag tests raise and drop `clk_present` with a mask that selects only one edge, so a swapped rise and fall bit, or an unmasked interrupt, is caught at the `irq` pin.

// File: rtl/osc_ctrl_pkg.sv
package osc_ctrl_pkg;

  localparam int unsigned OFF_CTRL  = 'h00;
  localparam int unsigned OFF_SETUP = 'h04;
  localparam int unsigned OFF_TRIM  = 'h08;
  localparam int unsigned OFF_STAT  = 'h0C;
  localparam int unsigned OFF_FLAGS = 'h10;
  localparam int unsigned OFF_MASK  = 'h14;
  localparam int unsigned OFF_BUSY  = 'h18;
  localparam int unsigned OFF_KEY   = 'h1C;

  localparam logic [15:0] UNLOCK_KEY = 16'd6688;

  localparam int unsigned NFLAG   = 4;
  localparam int unsigned FL_RDY  = 0;
  localparam int unsigned FL_RISE = 1;
  localparam int unsigned FL_FALL = 2;
  localparam int unsigned FL_FAIL = 3;

  typedef struct packed {
    logic fail_wake;
    logic fail_det;
    logic no_demand;
    logic force_en;
  } ctrl_t;

  typedef struct packed {
    logic [2:0] tmo;
    logic [1:0] mode;
    logic       hi_amp;
    logic       agc;
  } setup_t;

  typedef struct packed {
    logic [1:0] gain;
    logic [6:0] tune;
  } trim_t;

  // start-up wait in oscillator ticks for each code
  function automatic logic [16:0] tmo_ticks(input logic [2:0] code);
    logic [16:0] n;
    case (code)
      3'd0:    n = 17'd2;
      3'd1:    n = 17'd256;
      default: n = 17'd1 << (32'(code) + 8);
    endcase
    return n;
  endfunction

endpackage

// File: rtl/osc_startup.sv
module osc_startup
  import osc_ctrl_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       force_en,
  input  logic       no_demand,
  input  logic       demand_req,
  input  logic       osc_tick,
  input  logic [2:0] tmo_code,
  output logic       osc_en,
  output logic       osc_rdy
);

  logic             want_en;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;
  logic [16:0]      ticks;

  assign want_en  = force_en | (demand_req & ~no_demand);
  assign ticks    = tmo_ticks(tmo_code);
  assign last_cnt = CNT_W'(ticks - 17'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      osc_en  <= 1'b0;
      osc_rdy <= 1'b0;
      cnt_q   <= '0;
    end else begin
      osc_en <= want_en;
      if (!want_en || !osc_en) begin
        osc_rdy <= 1'b0;
        cnt_q   <= '0;
      end else if (osc_tick && !osc_rdy) begin
        if (cnt_q == last_cnt) begin
          osc_rdy <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/osc_irq.sv
module osc_irq
  import osc_ctrl_pkg::*;
#(
  parameter int unsigned SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             osc_rdy,
  input  logic             clk_present,
  input  logic             osc_fail,
  input  logic             fail_det,
  input  logic [NFLAG-1:0] flag_clr,
  input  logic [NFLAG-1:0] mask,
  output logic [NFLAG-1:0] flags,
  output logic             irq
);

  logic [SYNC_N-1:0] sync_q;
  logic              pres_q;
  logic              rdy_q;
  logic              pres_s;
  logic [NFLAG-1:0]  set_v;

  assign pres_s = sync_q[SYNC_N-1];

  always_comb begin
    set_v          = '0;
    set_v[FL_RDY]  = osc_rdy & ~rdy_q;
    set_v[FL_RISE] = pres_s & ~pres_q;
    set_v[FL_FALL] = ~pres_s & pres_q;
    set_v[FL_FAIL] = osc_fail & fail_det;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      pres_q <= 1'b0;
      rdy_q  <= 1'b0;
      flags  <= '0;
      irq    <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], clk_present};
      pres_q <= pres_s;
      rdy_q  <= osc_rdy;
      flags  <= (flags & ~flag_clr) | set_v;
      irq    <= |(flags & mask);
    end
  end

endmodule

// File: rtl/osc_regs.sv
module osc_regs
  import osc_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  input  logic              osc_tick,
  input  logic              osc_en,
  input  logic              osc_rdy,
  input  logic [NFLAG-1:0]  flags,
  output ctrl_t             ctrl_q,
  output setup_t            setup_q,
  output trim_t             trim_q,
  output logic [NFLAG-1:0]  mask_q,
  output logic [NFLAG-1:0]  flag_clr,
  output logic              locked_q,
  output logic              busy_q
);

  logic hit_ctrl, hit_setup, hit_trim, hit_flags, hit_mask, hit_key;
  logic forced_off;
  logic wr_ctrl, wr_setup, wr_trim;
  logic unused_bits;

  assign hit_ctrl  = bus_addr == ADDR_W'(OFF_CTRL);
  assign hit_setup = bus_addr == ADDR_W'(OFF_SETUP);
  assign hit_trim  = bus_addr == ADDR_W'(OFF_TRIM);
  assign hit_flags = bus_addr == ADDR_W'(OFF_FLAGS);
  assign hit_mask  = bus_addr == ADDR_W'(OFF_MASK);
  assign hit_key   = bus_addr == ADDR_W'(OFF_KEY);

  assign forced_off = ctrl_q.no_demand & ~ctrl_q.force_en;
  assign wr_ctrl    = bus_wr & hit_ctrl & ~locked_q;
  assign wr_setup   = bus_wr & hit_setup & ~locked_q & forced_off;
  assign wr_trim    = bus_wr & hit_trim & ~locked_q & ~busy_q;
  assign flag_clr   = (bus_wr & hit_flags) ? bus_wdata[NFLAG-1:0] : '0;
  assign unused_bits = ^bus_wdata[31:16];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      setup_q  <= '0;
      trim_q   <= '0;
      mask_q   <= '0;
      locked_q <= 1'b0;
      busy_q   <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q <= '{fail_wake: bus_wdata[5], fail_det: bus_wdata[4],
                    no_demand: bus_wdata[1], force_en: bus_wdata[0]};
      end
      if (wr_setup) begin
        setup_q <= '{tmo: bus_wdata[10:8], mode: bus_wdata[5:4],
                     hi_amp: bus_wdata[1], agc: bus_wdata[0]};
      end
      if (wr_trim) begin
        trim_q <= '{gain: bus_wdata[9:8], tune: bus_wdata[6:0]};
      end
      if (bus_wr && hit_mask) begin
        mask_q <= bus_wdata[NFLAG-1:0];
      end
      if (bus_wr && hit_key) begin
        locked_q <= (bus_wdata[15:0] != UNLOCK_KEY);
      end
      if (wr_trim) begin
        busy_q <= 1'b1;
      end else if (osc_tick) begin
        busy_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      unique case (32'(bus_addr))
        OFF_CTRL:  bus_rdata <= {26'b0, ctrl_q.fail_wake, ctrl_q.fail_det, 2'b0,
                                 ctrl_q.no_demand, ctrl_q.force_en};
        OFF_SETUP: bus_rdata <= {21'b0, setup_q.tmo, 2'b0, setup_q.mode, 2'b0,
                                 setup_q.hi_amp, setup_q.agc};
        OFF_TRIM:  bus_rdata <= {22'b0, trim_q.gain, 1'b0, trim_q.tune};
        OFF_STAT:  bus_rdata <= {locked_q, 14'b0, osc_en, 15'b0, osc_rdy};
        OFF_FLAGS: bus_rdata <= {{(32-NFLAG){1'b0}}, flags};
        OFF_MASK:  bus_rdata <= {{(32-NFLAG){1'b0}}, mask_q};
        OFF_BUSY:  bus_rdata <= {31'b0, busy_q};
        default:   bus_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/osc_startup_ctrl.sv
module osc_startup_ctrl
  import osc_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  input  logic              osc_tick,
  input  logic              demand_req,
  input  logic              clk_present,
  input  logic              osc_fail,
  output logic              osc_en,
  output logic              osc_rdy,
  output logic              irq
);

  ctrl_t            ctrl_q;
  setup_t           setup_q;
  trim_t            trim_q;
  logic [NFLAG-1:0] mask_q;
  logic [NFLAG-1:0] flag_clr;
  logic [NFLAG-1:0] flags_q;
  logic             locked_q;
  logic             busy_q;
  logic             unused_trim;

  assign unused_trim = ^{trim_q, busy_q};

  osc_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .osc_tick(osc_tick), .osc_en(osc_en), .osc_rdy(osc_rdy), .flags(flags_q),
    .ctrl_q(ctrl_q), .setup_q(setup_q), .trim_q(trim_q), .mask_q(mask_q),
    .flag_clr(flag_clr), .locked_q(locked_q), .busy_q(busy_q)
  );

  osc_startup #(.CNT_W(CNT_W)) u_start (
    .clk(clk), .rst(rst), .force_en(ctrl_q.force_en),
    .no_demand(ctrl_q.no_demand), .demand_req(demand_req),
    .osc_tick(osc_tick), .tmo_code(setup_q.tmo),
    .osc_en(osc_en), .osc_rdy(osc_rdy)
  );

  osc_irq #(.SYNC_N(SYNC_N)) u_irq (
    .clk(clk), .rst(rst), .osc_rdy(osc_rdy), .clk_present(clk_present),
    .osc_fail(osc_fail), .fail_det(ctrl_q.fail_det), .flag_clr(flag_clr),
    .mask(mask_q), .flags(flags_q), .irq(irq)
  );

endmodule

// File: rtl/osc_ctrl_chk.sv
module osc_ctrl_chk
  import osc_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              demand_req,
  input logic              force_en,
  input logic              no_demand,
  input logic              fail_det,
  input logic [3:0]        ctrl_bits,
  input logic              locked,
  input logic [NFLAG-1:0]  flags,
  input logic [NFLAG-1:0]  mask,
  input logic              osc_en,
  input logic              osc_rdy,
  input logic              irq
);

  p_force_on_r1: assert property (@(posedge clk) disable iff (rst)
    force_en |=> osc_en);
  p_demand_on_r1: assert property (@(posedge clk) disable iff (rst)
    (demand_req && !no_demand) |=> osc_en);
  p_forced_off_r1: assert property (@(posedge clk) disable iff (rst)
    (no_demand && !force_en) |=> !osc_en);
  p_rdy_needs_en_r3: assert property (@(posedge clk) disable iff (rst)
    osc_rdy |-> osc_en);
  p_lock_ctrl_r5: assert property (@(posedge clk) disable iff (rst)
    (locked && bus_wr && bus_addr == ADDR_W'(OFF_CTRL)) |=> ctrl_bits == $past(ctrl_bits));
  p_rdy_flag_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(osc_rdy) |=> flags[FL_RDY]);
  p_fail_gate_r9: assert property (@(posedge clk) disable iff (rst)
    (!fail_det && !flags[FL_FAIL]) |=> !flags[FL_FAIL]);
  p_irq_on_r11: assert property (@(posedge clk) disable iff (rst)
    (|(flags & mask)) |=> irq);
  p_irq_off_r11: assert property (@(posedge clk) disable iff (rst)
    !(|(flags & mask)) |=> !irq);

endmodule

bind osc_startup_ctrl osc_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .demand_req(demand_req), .force_en(ctrl_q.force_en),
  .no_demand(ctrl_q.no_demand), .fail_det(ctrl_q.fail_det),
  .ctrl_bits(ctrl_q), .locked(locked_q), .flags(flags_q), .mask(mask_q),
  .osc_en(osc_en), .osc_rdy(osc_rdy), .irq(irq)
);

// File: tb/tb_osc_startup_ctrl.sv
module tb_osc_startup_ctrl;

  localparam int unsigned AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_rd = 1'b0;
  logic [31:0]   bus_rdata;
  logic          osc_tick = 1'b0;
  logic          demand_req = 1'b0;
  logic          clk_present = 1'b0;
  logic          osc_fail = 1'b0;
  logic          osc_en, osc_rdy, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t exp_q[$];
  logic rd_d = 1'b0;

  always #10 clk = ~clk;

  osc_startup_ctrl #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .osc_tick(osc_tick), .demand_req(demand_req), .clk_present(clk_present),
    .osc_fail(osc_fail), .osc_en(osc_en), .osc_rdy(osc_rdy), .irq(irq)
  );

  // monitor: compares read data one cycle after each read strobe
  always @(posedge clk) rd_d <= bus_rd;
  always @(negedge clk) begin
    if (rd_d) begin
      item_t it;
      it = exp_q.pop_front();
      checks++;
      if (bus_rdata !== it.exp) begin
        errors++;
        $display("FAIL %s: rdata=%h expected=%h", it.tag, bus_rdata, it.exp);
      end
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = AW'(a); bus_rd = 1'b1;
    it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(negedge clk);
      osc_tick = 1'b1;
    end
    @(negedge clk);
    osc_tick = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // reset state
    check("R12 reset osc_en", osc_en, 1'b0);
    check("R12 reset osc_rdy", osc_rdy, 1'b0);
    check("R12 reset irq", irq, 1'b0);
    rd('h0C, 32'h0, "R4 status after reset");
    rd('h00, 32'h0, "R12 control after reset");

    // enable rule
    demand_req = 1'b1; idle(2);
    check("R1 demand enables", osc_en, 1'b1);
    wr('h00, 32'h2); idle(2);
    check("R1 no-demand blocks request", osc_en, 1'b0);
    demand_req = 1'b0;

    // setup gated by forced-off
    wr('h04, 32'h123);
    rd('h04, 32'h123, "R6 setup write while forced off");
    wr('h00, 32'h1); idle(2);
    check("R1 force enables", osc_en, 1'b1);
    wr('h04, 32'h0);
    rd('h04, 32'h123, "R6 setup write ignored while running");
    rd('h0C, 32'h0001_0000, "R4 status enabled");

    // start-up wait code 1 = 256 ticks
    tick(255);
    check("R2 not ready at 255 of 256", osc_rdy, 1'b0);
    tick(1);
    check("R2 ready after 256", osc_rdy, 1'b1);
    rd('h0C, 32'h0001_0001, "R4 status ready");
    rd('h10, 32'h1, "R8 ready flag");
    wr('h10, 32'h1);
    rd('h10, 32'h0, "R10 ready flag cleared");

    // loss of enable and restart with code 0 = 2 ticks
    wr('h00, 32'h2); idle(2);
    check("R3 ready drops with enable", osc_rdy, 1'b0);
    check("R3 enable dropped", osc_en, 1'b0);
    wr('h04, 32'h023);
    wr('h00, 32'h1); idle(2);
    tick(1);
    check("R3 count restarted", osc_rdy, 1'b0);
    tick(1);
    check("R2 ready after 2 ticks", osc_rdy, 1'b1);

    // clock-present edges
    clk_present = 1'b1; idle(6);
    rd('h10, 32'h3, "R8 rise flag");
    clk_present = 1'b0; idle(6);
    rd('h10, 32'h7, "R8 fall flag");
    wr('h10, 32'h2);
    rd('h10, 32'h5, "R10 clear only rise");
    wr('h10, 32'h5);
    rd('h10, 32'h0, "R10 clear rest");

    // failure flag gating
    osc_fail = 1'b1; idle(3);
    rd('h10, 32'h0, "R9 fail ignored when detect off");
    wr('h00, 32'h11); idle(2);
    rd('h10, 32'h8, "R9 fail flag with detect on");
    osc_fail = 1'b0;
    wr('h10, 32'h8);
    rd('h10, 32'h0, "R10 fail flag cleared");

    // interrupt masking
    wr('h14, 32'h4);
    clk_present = 1'b1; idle(6);
    check("R11 masked rise no irq", irq, 1'b0);
    clk_present = 1'b0; idle(6);
    check("R11 unmasked fall irq", irq, 1'b1);
    rd('h14, 32'h4, "R11 mask readback");
    wr('h10, 32'h6); idle(2);
    check("R11 irq drops after clear", irq, 1'b0);

    // trim busy
    wr('h08, 32'h255);
    rd('h08, 32'h255, "R7 trim write");
    rd('h18, 32'h1, "R7 busy set");
    wr('h08, 32'h100);
    rd('h08, 32'h255, "R7 trim ignored while busy");
    tick(1);
    rd('h18, 32'h0, "R7 busy cleared by tick");
    wr('h08, 32'h100);
    rd('h08, 32'h100, "R7 trim accepted after busy");
    tick(1);

    // lock key
    wr('h1C, 32'h1234);
    rd('h0C, 32'h8001_0001, "R5 locked status");
    wr('h00, 32'h2); idle(2);
    rd('h00, 32'h11, "R5 control write ignored when locked");
    check("R5 still enabled", osc_en, 1'b1);
    wr('h08, 32'h07F);
    rd('h08, 32'h100, "R5 trim write ignored when locked");
    rd('h1C, 32'h0, "R5 key reads zero");
    wr('h1C, 32'h1A20);
    rd('h0C, 32'h0001_0001, "R5 unlocked status");
    wr('h00, 32'hFFFF_FFFF);
    rd('h00, 32'h33, "R12 control field mask");
    wr('h00, 32'h2);
    wr('h04, 32'hFFFF_FFFF);
    rd('h04, 32'h733, "R12 setup field mask");

    idle(3);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule